// File: doc/BRIEF.md
# Burst Column Address Generator

This block produces the column address stream for one read or write burst of a synchronous DRAM. A start strobe captures a start column, a burst-length code and an ordering bit. From the clock edge that samples the strobe onward, the block presents one column address per clock, a valid flag and a flag that marks the final beat. The burst ends in one of three ways: it completes, a stop strobe arrives, or a new start strobe replaces it.

Two orderings are supported inside an aligned block of 2, 4 or 8 columns. Sequential ordering counts the low bits upward and wraps inside the block. Interleaved ordering XORs the beat index into the low start bits. In both orderings the column bits above the block boundary keep their start values. A full-page length walks upward through every column of the row, wraps from the top column to column 0, and runs until it is stopped or replaced. A length code that is not defined, and interleaved ordering requested together with full page, both fall back to a single beat and raise an error flag.

Top module: `burst_col_gen`

## Requirements
- R1: While reset is high, and after its release until the first start, valid_o, last_o and err_o are 0.
- R2: With len_code_i 001/010/011 (2/4/8 beats) and order_i=0, beat i presents the start column with its low log2(length) bits replaced by (start low bits + i) modulo the length. The upper bits are unchanged.
- R3: With len_code_i 001/010/011 and order_i=1, beat i presents the start column with its low log2(length) bits XORed with i. For example, length 8 from 5 gives 5,4,7,6,1,0,3,2.
- R4: With len_code_i=111 and order_i=0, beat i presents (start + i) mod 2^COL_W. The burst has no end of its own, and last_o is never 1.
- R5: A finite burst keeps valid_o high for exactly its length in beats (code 000 gives 1 beat). last_o is 1 only on the final beat. valid_o falls on the following clock.
- R6: A stop_i sampled during an active burst without start_i makes valid_o low on the next clock.
- R7: A start_i sampled during an active burst aborts it. The next clock presents the new start column as beat 0 of the new burst.
- R8: Codes 100, 101, 110, and code 111 with order_i=1, produce a one-beat burst at the start column with err_o=1. err_o holds until the next start and is 0 after a start with a valid combination.
- R9: When start_i and stop_i are sampled together, the start wins and a new burst begins.
- R10: stop_i while no burst is active leaves valid_o and last_o at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Start strobe; captures column, length code and ordering |
| start_col_i | input | COL_W | Start column |
| len_code_i | input | 3 | Burst length code: 000=1, 001=2, 010=4, 011=8, 111=full page |
| order_i | input | 1 | 0 sequential, 1 interleaved |
| stop_i | input | 1 | Stop strobe; ends the active burst on the next clock |
| col_o | output | COL_W | Current column address |
| valid_o | output | 1 | col_o holds a beat of the active burst |
| last_o | output | 1 | Final beat of a finite burst |
| err_o | output | 1 | Last start used an undefined length/ordering combination |

## Verification
Every start column from 0 to 255 is tried with each finite length under both orderings. This separates an adding wrap from an XOR pattern and catches any disturbance of the bits above the block boundary. A long full-page run from near the top of the row shows the wrap through column 0 and the absence of a last beat, and a stop shows the exit. Aborts by a new start, a start arriving together with a stop, a stop while idle, and each undefined code show how commands interact and how the error flag is set and cleared.

// File: rtl/bcg_pkg.sv
package bcg_pkg;
   localparam logic [2:0] LEN_ONE   = 3'b000;
   localparam logic [2:0] LEN_TWO   = 3'b001;
   localparam logic [2:0] LEN_FOUR  = 3'b010;
   localparam logic [2:0] LEN_EIGHT = 3'b011;
   localparam logic [2:0] LEN_PAGE  = 3'b111;

   typedef enum logic {
      ORD_SEQ = 1'b0,
      ORD_XOR = 1'b1
   } order_t;
endpackage

// File: rtl/bcg_len_decode.sv
module bcg_len_decode
   import bcg_pkg::*;
#(
   parameter int COL_W = 8
) (
   input  logic [2:0]       code_i,
   input  order_t           ord_i,
   output logic [COL_W-1:0] mask_o,
   output logic             full_o,
   output logic             err_o
);
   always_comb begin
      mask_o = '0;
      full_o = 1'b0;
      err_o  = 1'b0;
      case (code_i)
         LEN_ONE:   mask_o = '0;
         LEN_TWO:   mask_o = COL_W'(1);
         LEN_FOUR:  mask_o = COL_W'(3);
         LEN_EIGHT: mask_o = COL_W'(7);
         LEN_PAGE: begin
            if (ord_i == ORD_XOR) begin
               err_o = 1'b1;
            end else begin
               mask_o = '1;
               full_o = 1'b1;
            end
         end
         default:   err_o = 1'b1;
      endcase
   end
endmodule

// File: rtl/bcg_beat_ctr.sv
module bcg_beat_ctr #(
   parameter int COL_W = 8
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             start_i,
   input  logic             stop_i,
   input  logic [COL_W-1:0] mask_i,
   input  logic             full_i,
   output logic [COL_W-1:0] beat_o,
   output logic [COL_W-1:0] mask_o,
   output logic             valid_o,
   output logic             last_o
);
   logic [COL_W-1:0] beat_q;
   logic [COL_W-1:0] mask_q;
   logic             full_q;
   logic             valid_q;
   logic             at_end;

   assign at_end = valid_q && !full_q && (beat_q == mask_q);

   always_ff @(posedge clk) begin
      if (rst) begin
         beat_q  <= '0;
         mask_q  <= '0;
         full_q  <= 1'b0;
         valid_q <= 1'b0;
      end else if (start_i) begin
         beat_q  <= '0;
         mask_q  <= mask_i;
         full_q  <= full_i;
         valid_q <= 1'b1;
      end else if (valid_q) begin
         if (stop_i || at_end) begin
            valid_q <= 1'b0;
         end else begin
            beat_q <= beat_q + COL_W'(1);
         end
      end
   end

   assign beat_o  = beat_q;
   assign mask_o  = mask_q;
   assign valid_o = valid_q;
   assign last_o  = at_end;
endmodule

// File: rtl/bcg_col_map.sv
module bcg_col_map
   import bcg_pkg::*;
#(
   parameter int COL_W  = 8,
   parameter bit XOR_EN = 1'b1
) (
   input  logic [COL_W-1:0] base_i,
   input  logic [COL_W-1:0] beat_i,
   input  logic [COL_W-1:0] mask_i,
   input  order_t           ord_i,
   output logic [COL_W-1:0] col_o
);
   logic [COL_W-1:0] low;

   generate
      if (XOR_EN) begin : g_both
         assign low = (ord_i == ORD_XOR) ? (base_i ^ beat_i) : (base_i + beat_i);
      end else begin : g_seq_only
         logic unused_ord;
         assign unused_ord = ord_i;
         assign low = base_i + beat_i;
      end
   endgenerate

   assign col_o = (base_i & ~mask_i) | (low & mask_i);
endmodule

// File: rtl/burst_col_gen.sv
module burst_col_gen
   import bcg_pkg::*;
#(
   parameter int COL_W  = 8,
   parameter bit XOR_EN = 1'b1
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             start_i,
   input  logic [COL_W-1:0] start_col_i,
   input  logic [2:0]       len_code_i,
   input  logic             order_i,
   input  logic             stop_i,
   output logic [COL_W-1:0] col_o,
   output logic             valid_o,
   output logic             last_o,
   output logic             err_o
);
   generate
      if (COL_W < 3) begin : g_bad_width
         $error("burst_col_gen: COL_W must be at least 3");
      end
   endgenerate

   order_t           ord_in;
   order_t           ord_q;
   logic [COL_W-1:0] base_q;
   logic             err_q;
   logic [COL_W-1:0] dec_mask;
   logic             dec_full;
   logic             dec_err;
   logic [COL_W-1:0] beat;
   logic [COL_W-1:0] act_mask;

   assign ord_in = XOR_EN ? order_t'(order_i) : ORD_SEQ;

   bcg_len_decode #(.COL_W(COL_W)) u_dec (
      .code_i (len_code_i),
      .ord_i  (order_t'(order_i)),
      .mask_o (dec_mask),
      .full_o (dec_full),
      .err_o  (dec_err)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         base_q <= '0;
         ord_q  <= ORD_SEQ;
         err_q  <= 1'b0;
      end else if (start_i) begin
         base_q <= start_col_i;
         ord_q  <= ord_in;
         err_q  <= dec_err;
      end
   end

   bcg_beat_ctr #(.COL_W(COL_W)) u_ctr (
      .clk     (clk),
      .rst     (rst),
      .start_i (start_i),
      .stop_i  (stop_i),
      .mask_i  (dec_mask),
      .full_i  (dec_full),
      .beat_o  (beat),
      .mask_o  (act_mask),
      .valid_o (valid_o),
      .last_o  (last_o)
   );

   bcg_col_map #(.COL_W(COL_W), .XOR_EN(XOR_EN)) u_map (
      .base_i (base_q),
      .beat_i (beat),
      .mask_i (act_mask),
      .ord_i  (ord_q),
      .col_o  (col_o)
   );

   assign err_o = err_q;
endmodule

// File: rtl/bcg_checker.sv
module bcg_checker #(
   parameter int COL_W = 8
) (
   input logic             clk,
   input logic             rst,
   input logic             start_i,
   input logic [COL_W-1:0] start_col_i,
   input logic [2:0]       len_code_i,
   input logic             order_i,
   input logic             stop_i,
   input logic [COL_W-1:0] col_o,
   input logic             valid_o,
   input logic             last_o,
   input logic             err_o
);
   logic page_q;
   logic bad_cfg;

   assign bad_cfg = (len_code_i == 3'b100) || (len_code_i == 3'b101) ||
                    (len_code_i == 3'b110) || (len_code_i == 3'b111 && order_i);

   always_ff @(posedge clk) begin
      if (rst) page_q <= 1'b0;
      else if (start_i) page_q <= (len_code_i == 3'b111) && !order_i;
   end

   assert_reset_idle_R1: assert property (@(posedge clk) rst |=> !valid_o && !err_o);
   assert_last_in_burst_R5: assert property (@(posedge clk) disable iff (rst)
      last_o |-> valid_o);
   assert_last_ends_R5: assert property (@(posedge clk) disable iff (rst)
      last_o && !start_i |=> !valid_o);
   assert_page_no_last_R4: assert property (@(posedge clk) disable iff (rst)
      page_q && valid_o |-> !last_o);
   assert_page_step_R4: assert property (@(posedge clk) disable iff (rst)
      page_q && valid_o && !start_i && !stop_i |=> col_o == $past(col_o) + COL_W'(1));
   assert_stop_ends_R6: assert property (@(posedge clk) disable iff (rst)
      valid_o && stop_i && !start_i |=> !valid_o);
   assert_restart_R7: assert property (@(posedge clk) disable iff (rst)
      start_i |=> valid_o && col_o == $past(start_col_i));
   assert_bad_cfg_R8: assert property (@(posedge clk) disable iff (rst)
      start_i && bad_cfg |=> err_o && last_o);
   assert_idle_stop_R10: assert property (@(posedge clk) disable iff (rst)
      !valid_o && !start_i |=> !valid_o);
endmodule

bind burst_col_gen bcg_checker #(.COL_W(COL_W)) u_chk (
   .clk         (clk),
   .rst         (rst),
   .start_i     (start_i),
   .start_col_i (start_col_i),
   .len_code_i  (len_code_i),
   .order_i     (order_i),
   .stop_i      (stop_i),
   .col_o       (col_o),
   .valid_o     (valid_o),
   .last_o      (last_o),
   .err_o       (err_o)
);

// File: tb/burst_col_gen_test.sv
module burst_col_gen_test;
   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       start = 1'b0;
   logic [7:0] scol = '0;
   logic [2:0] len = '0;
   logic       ord = 1'b0;
   logic       stop = 1'b0;
   logic [7:0] col;
   logic       valid, last, err;
   int         total = 0;
   int         bad = 0;

   always #10 clk = ~clk;

   burst_col_gen uut (
      .clk(clk), .rst(rst), .start_i(start), .start_col_i(scol),
      .len_code_i(len), .order_i(ord), .stop_i(stop),
      .col_o(col), .valid_o(valid), .last_o(last), .err_o(err)
   );

   task automatic chk(input string req, input string what, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   task automatic run_burst(input logic [7:0] c, input logic [2:0] code, input logic typ,
                            input int nb, input logic eerr, input string req);
      @(negedge clk);
      start = 1'b1; scol = c; len = code; ord = typ;
      @(negedge clk);
      start = 1'b0;
      for (int i = 0; i < nb; i++) begin
         logic [7:0] m;
         logic [7:0] e;
         m = 8'(nb - 1);
         e = typ ? ((c & ~m) | ((c ^ 8'(i)) & m)) : ((c & ~m) | ((c + 8'(i)) & m));
         chk(req, "valid", int'(valid), 1);
         chk(req, "col", int'(col), int'(e));
         chk("R5", "last", int'(last), int'(i == nb - 1));
         chk("R8", "err", int'(err), int'(eerr));
         @(negedge clk);
      end
      chk("R5", "valid after end", int'(valid), 0);
   endtask

   initial begin
      #(200000 * 20);
      bad++; total++;
      $display("FAIL watchdog actual=running expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      chk("R1", "valid in reset", int'(valid), 0);
      chk("R1", "last in reset", int'(last), 0);
      chk("R1", "err in reset", int'(err), 0);
      rst = 1'b0;
      @(negedge clk);
      chk("R1", "valid after reset", int'(valid), 0);

      // R2 / R3 / R5 sweep: every start column, every finite length, both orders
      for (int code = 0; code < 4; code++)
         for (int typ = 0; typ < 2; typ++)
            for (int c = 0; c < 256; c++)
               run_burst(8'(c), 3'(code), typ[0], 1 << code, 1'b0, typ ? "R3" : "R2");

      // R4 full page from 250, wraps through 0, stopped by R6
      @(negedge clk);
      start = 1'b1; scol = 8'd250; len = 3'b111; ord = 1'b0;
      @(negedge clk);
      start = 1'b0;
      for (int i = 0; i < 300; i++) begin
         chk("R4", "page valid", int'(valid), 1);
         chk("R4", "page col", int'(col), (250 + i) % 256);
         chk("R4", "page last", int'(last), 0);
         if (i == 299) stop = 1'b1;
         @(negedge clk);
      end
      stop = 1'b0;
      chk("R6", "valid after stop", int'(valid), 0);

      // R6 stop in the middle of a finite burst
      @(negedge clk);
      start = 1'b1; scol = 8'h40; len = 3'b011; ord = 1'b1;
      @(negedge clk);
      start = 1'b0;
      chk("R6", "col beat0", int'(col), 8'h40);
      stop = 1'b1;
      @(negedge clk);
      stop = 1'b0;
      chk("R6", "valid after mid stop", int'(valid), 0);

      // R7 abort by new start
      @(negedge clk);
      start = 1'b1; scol = 8'h10; len = 3'b011; ord = 1'b0;
      @(negedge clk);
      start = 1'b0;
      chk("R7", "first col", int'(col), 8'h10);
      @(negedge clk);
      chk("R7", "second col", int'(col), 8'h11);
      start = 1'b1; scol = 8'h23; len = 3'b010; ord = 1'b0;
      @(negedge clk);
      start = 1'b0;
      for (int i = 0; i < 4; i++) begin
         chk("R7", "restart col", int'(col), 8'h20 | ((3 + i) % 4));
         chk("R7", "restart last", int'(last), int'(i == 3));
         @(negedge clk);
      end
      chk("R7", "restart end", int'(valid), 0);

      // R9 start and stop together
      @(negedge clk);
      start = 1'b1; scol = 8'h80; len = 3'b001; ord = 1'b0;
      @(negedge clk);
      scol = 8'h95; len = 3'b010; ord = 1'b1; stop = 1'b1;
      @(negedge clk);
      start = 1'b0; stop = 1'b0;
      chk("R9", "valid", int'(valid), 1);
      chk("R9", "col", int'(col), 8'h95);
      @(negedge clk);
      chk("R9", "col next", int'(col), 8'h94);

      // R10 stop while idle
      repeat (4) @(negedge clk);
      chk("R10", "idle before", int'(valid), 0);
      stop = 1'b1;
      @(negedge clk);
      stop = 1'b0;
      chk("R10", "valid", int'(valid), 0);
      chk("R10", "last", int'(last), 0);
      @(negedge clk);
      chk("R10", "valid later", int'(valid), 0);

      // R8 undefined combinations then recovery
      for (int code = 4; code < 7; code++)
         run_burst(8'(37 * code), 3'(code), 1'b0, 1, 1'b1, "R8");
      run_burst(8'hA7, 3'b111, 1'b1, 1, 1'b1, "R8");
      run_burst(8'hA7, 3'b010, 1'b0, 4, 1'b0, "R8");

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule